// File: doc/BRIEF.md
# SPI Receive Capture and Select Hold Overlay

This block sits next to an existing SPI controller. It does not drive the serial clock. It watches the serial clock, the controller's chip-select lines and the serial data input. It assembles every received byte and stores it into a ring of 32 words, each 64 bits wide. Software fetches any stored word by its index. Because the controller's own data path is not involved, the block gives full-duplex receive data for transfers in which the controller only transmits.

The block can also keep a chip select asserted after the controller releases it. This lets one device transaction span several controller commands of unknown total length. A single control word, written over a one-cycle write strobe, selects the capture edge, enables reception, sets the per-select hold bits and applies a soft reset.

All inputs are oversampled in the system clock domain through synchronizers. The serial clock therefore has to stay at each level for at least two system clocks.

Top module: `spi_cap_overlay`

## Requirements
- R1: The control word layout is: bit 2 capture polarity, bit 4 receive enable, bits 9:6 select hold (bit 6+n holds select n), bit 11 soft reset. All other bits are ignored. A write takes effect on the next clock.
- R2: With capture polarity 1, data is sampled on rising serial clock edges. With capture polarity 0, data is sampled on falling edges.
- R3: A bit is sampled only while receive enable is 1 and at least one controller select is low. While receive enable is 0, the ring and its pointers do not change.
- R4: Each stored byte is bit-reversed with respect to the wire. The first bit received lands in bit 0 of the byte and the eighth bit lands in bit 7.
- R5: Successive bytes fill byte lanes 0 to 7 of the current word, where lane k occupies bits 8k+7:8k. After lane 7 is filled, the word pointer advances by one.
- R6: When all controller selects return high and the current word is only partly filled, the word pointer advances, so the next transaction starts at lane 0 of the following word.
- R7: A byte that has fewer than 8 captured bits when the selects rise is dropped. The next transaction's first byte goes to the lane that follows the last complete byte, rounded up to the next word boundary under R6.
- R8: The word pointer counts modulo 32. After 256 bytes the next byte is written to lane 0 of word 0, and the other lanes of word 0 are left untouched.
- R9: `rd_data` shows the stored word selected by `rd_idx` in the same cycle.
- R10: While hold bit n is 1, `sel_n_o[n]` is low whatever the controller drives. While hold bit n is 0, `sel_n_o[n]` follows `sel_n_i[n]`.
- R11: While soft reset is 1, the word pointer, lane counter and bit counter are held at zero and nothing is captured. After soft reset is cleared, the first byte goes to word 0, lane 0.
- R12: After `rst_n` is released, the control word is all zeros: no capture takes place and all selects pass through. The counters start at word 0, lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 12 | Control word value |
| sclk_i | input | 1 | Serial clock from the controller |
| sdi_i | input | 1 | Serial data input from the device |
| sel_n_i | input | 4 | Active-low selects from the controller |
| sel_n_o | output | 4 | Active-low selects to the devices after hold |
| rd_idx | input | 5 | Index of the stored word to read |
| rd_data | output | 64 | Stored word at `rd_idx` |

## Verification
The hardest conditions to reach are the rounding cases: a select that rises after a partial byte, or after a partial word, and the pointer wrapping after exactly 256 bytes. The ports show these only through where the next transaction's bytes land. The bench therefore runs back-to-back transactions of chosen lengths (3 then 2 bytes; 1 byte plus 5 bits; one 256-byte burst followed by one byte). It then reads the words and lanes on each side of the boundary. Capture-edge selection is exercised by inverting the data line between the two clock edges of each bit, so sampling on the wrong edge yields the complemented byte.

// File: rtl/spi_cap_pkg.sv
package spi_cap_pkg;

    localparam int CTL_W    = 12;
    localparam int NUM_SEL  = 4;
    localparam int CPOL_BIT = 2;
    localparam int RXEN_BIT = 4;
    localparam int HOLD_LSB = 6;
    localparam int SRST_BIT = 11;
    localparam int BYTE_W   = 8;
    localparam int BCNT_W   = $clog2(BYTE_W);

    typedef struct packed {
        logic               srst;
        logic [NUM_SEL-1:0] hold;
        logic               rx_en;
        logic               cap_pol;
    } ctl_t;

endpackage

// File: rtl/spi_cap_ctl.sv
module spi_cap_ctl
    import spi_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    output ctl_t             ctl_o
);

    ctl_t ctl_d, ctl_q;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[1:0], cfg_wdata[3], cfg_wdata[5], cfg_wdata[10]};

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we) begin
            ctl_d.cap_pol = cfg_wdata[CPOL_BIT];
            ctl_d.rx_en   = cfg_wdata[RXEN_BIT];
            ctl_d.hold    = cfg_wdata[HOLD_LSB +: NUM_SEL];
            ctl_d.srst    = cfg_wdata[SRST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/spi_cap_edge.sv
module spi_cap_edge #(
    parameter int NUM_SEL = 4,
    parameter int SYNC    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sdi_i,
    input  logic [NUM_SEL-1:0] sel_n_i,
    input  logic               cap_pol_i,
    output logic               cap_stb_o,
    output logic               bit_o,
    output logic               act_o,
    output logic               end_o
);

    typedef struct packed {
        logic [SYNC-1:0] sclk;
        logic [SYNC-1:0] sdi;
        logic [SYNC-1:0] act;
        logic            sclk_prev;
        logic            act_prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk      = {st_q.sclk[SYNC-2:0], sclk_i};
        st_d.sdi       = {st_q.sdi[SYNC-2:0], sdi_i};
        st_d.act       = {st_q.act[SYNC-2:0], ~&sel_n_i};
        st_d.sclk_prev = st_q.sclk[SYNC-1];
        st_d.act_prev  = st_q.act[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o     = st_q.act[SYNC-1];
    assign bit_o     = st_q.sdi[SYNC-1];
    assign end_o     = st_q.act_prev && !st_q.act[SYNC-1];
    assign cap_stb_o = st_q.act[SYNC-1]
                    && (st_q.sclk[SYNC-1] != st_q.sclk_prev)
                    && (st_q.sclk[SYNC-1] == cap_pol_i);

endmodule

// File: rtl/spi_cap_packer.sv
module spi_cap_packer
    import spi_cap_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int LANES = 8,
    localparam int PTR_W  = $clog2(WORDS),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_i,
    input  logic              rx_en_i,
    input  logic              cap_stb_i,
    input  logic              bit_i,
    input  logic              end_i,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_word_o,
    output logic [LANE_W-1:0] wr_lane_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic [BCNT_W-1:0] bitcnt_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [BCNT_W-1:0] bitcnt;
        logic [LANE_W-1:0] lane;
        logic [PTR_W-1:0]  wptr;
    } pack_t;

    pack_t pk_d, pk_q;
    logic  wr_en;
    logic [BYTE_W-1:0] next_byte;

    // first wire bit shifts down to bit 0 after a full byte
    assign next_byte = {bit_i, pk_q.shreg[BYTE_W-1:1]};

    always_comb begin
        pk_d  = pk_q;
        wr_en = 1'b0;
        if (srst_i) begin
            pk_d = '0;
        end else if (rx_en_i) begin
            if (end_i) begin
                pk_d.bitcnt = '0;
                if (pk_q.lane != '0) begin
                    pk_d.lane = '0;
                    pk_d.wptr = pk_q.wptr + 1'b1;
                end
            end else if (cap_stb_i) begin
                pk_d.shreg  = next_byte;
                pk_d.bitcnt = pk_q.bitcnt + 1'b1;
                if (pk_q.bitcnt == BCNT_W'(BYTE_W - 1)) begin
                    wr_en     = 1'b1;
                    pk_d.lane = pk_q.lane + 1'b1;
                    if (pk_q.lane == LANE_W'(LANES - 1)) begin
                        pk_d.wptr = pk_q.wptr + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign wr_en_o   = wr_en;
    assign wr_word_o = pk_q.wptr;
    assign wr_lane_o = pk_q.lane;
    assign wr_byte_o = next_byte;
    assign bitcnt_o  = pk_q.bitcnt;

endmodule

// File: rtl/spi_cap_ring.sv
module spi_cap_ring
    import spi_cap_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int LANES = 8,
    localparam int PTR_W  = $clog2(WORDS),
    localparam int LANE_W = $clog2(LANES),
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_word_i,
    input  logic [LANE_W-1:0] wr_lane_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_word_i][wr_lane_i * BYTE_W +: BYTE_W] <= wr_byte_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/spi_cap_overlay.sv
module spi_cap_overlay
    import spi_cap_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int LANES = 8,
    parameter int SYNC  = 2,
    localparam int PTR_W  = $clog2(WORDS),
    localparam int LANE_W = $clog2(LANES),
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CTL_W-1:0]   cfg_wdata,
    input  logic               sclk_i,
    input  logic               sdi_i,
    input  logic [NUM_SEL-1:0] sel_n_i,
    output logic [NUM_SEL-1:0] sel_n_o,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data
);

    ctl_t              ctl_q;
    logic              srst, rx_en;
    logic              cap_stb, cap_bit, sel_act, sel_end;
    logic              wr_en;
    logic [PTR_W-1:0]  wptr;
    logic [LANE_W-1:0] lane;
    logic [BYTE_W-1:0] wr_byte;
    logic [BCNT_W-1:0] bitcnt;

    assign srst  = ctl_q.srst;
    assign rx_en = ctl_q.rx_en;

    spi_cap_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctl_o     (ctl_q)
    );

    spi_cap_edge #(.NUM_SEL(NUM_SEL), .SYNC(SYNC)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .sdi_i     (sdi_i),
        .sel_n_i   (sel_n_i),
        .cap_pol_i (ctl_q.cap_pol),
        .cap_stb_o (cap_stb),
        .bit_o     (cap_bit),
        .act_o     (sel_act),
        .end_o     (sel_end)
    );

    spi_cap_packer #(.WORDS(WORDS), .LANES(LANES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (srst),
        .rx_en_i   (rx_en),
        .cap_stb_i (cap_stb),
        .bit_i     (cap_bit),
        .end_i     (sel_end),
        .wr_en_o   (wr_en),
        .wr_word_o (wptr),
        .wr_lane_o (lane),
        .wr_byte_o (wr_byte),
        .bitcnt_o  (bitcnt)
    );

    spi_cap_ring #(.WORDS(WORDS), .LANES(LANES)) u_ring (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_word_i (wptr),
        .wr_lane_i (lane),
        .wr_byte_i (wr_byte),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    // per-select hold: a set hold bit forces the select low
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_hold
        assign sel_n_o[g] = sel_n_i[g] & ~ctl_q.hold[g];
    end

endmodule

// File: rtl/spi_cap_chk.sv
module spi_cap_chk
    import spi_cap_pkg::*;
#(
    parameter int PTR_W  = 5,
    parameter int LANE_W = 3,
    parameter int LANES  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [CTL_W-1:0]   cfg_wdata,
    input logic [NUM_SEL-1:0] sel_n_o,
    input logic               srst,
    input logic               rx_en,
    input logic               sel_act,
    input logic               wr_en,
    input logic [PTR_W-1:0]   wptr,
    input logic [LANE_W-1:0]  lane,
    input logic [BCNT_W-1:0]  bitcnt
);

    AST_HOLD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (($past(cfg_wdata[HOLD_LSB +: NUM_SEL]) & sel_n_o) == '0)); // R10

    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (wptr == '0 && lane == '0 && bitcnt == '0)); // R11

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !srst) |=> ($stable(wptr) && $stable(lane) && $stable(bitcnt))); // R3

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane == LANE_W'(LANES - 1)) |=>
            (lane == '0 && wptr == PTR_W'($past(wptr) + 1'b1))); // R8

    AST_RELEASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel_act) && rx_en && !srst) |=> (lane == '0 && bitcnt == '0)); // R6

endmodule

bind spi_cap_overlay spi_cap_chk #(.PTR_W(PTR_W), .LANE_W(LANE_W), .LANES(LANES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sel_n_o   (sel_n_o),
    .srst      (srst),
    .rx_en     (rx_en),
    .sel_act   (sel_act),
    .wr_en     (wr_en),
    .wptr      (wptr),
    .lane      (lane),
    .bitcnt    (bitcnt)
);

// File: tb/spi_cap_overlay_tb_top.sv
module spi_cap_overlay_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [3:0]  sel_n = 4'hF;
    logic [3:0]  sel_n_o;
    logic [4:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] txbuf [256];

    always #10 clk = ~clk;

    spi_cap_overlay dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sclk_i    (sclk),
        .sdi_i     (sdi),
        .sel_n_i   (sel_n),
        .sel_n_o   (sel_n_o),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // control word: bit2 capture pol, bit4 rx enable, bits 9:6 hold, bit 11 soft reset (R1)
    task automatic write_ctl(input bit pol, input bit rxen, input logic [3:0] hold, input bit srst);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = '0;
        cfg_wdata[2] = pol;
        cfg_wdata[4] = rxen;
        cfg_wdata[9:6] = hold;
        cfg_wdata[11] = srst;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // data is inverted between the capture edge and the other edge
    task automatic shift_bits(input logic [7:0] b, input int n, input bit pol);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            tick(2);
            sclk = pol;
            tick(2);
            sdi = ~b[i];
            sclk = ~pol;
            tick(2);
        end
    endtask

    task automatic xfer(input int sel, input int nbytes, input int extra_bits, input bit pol);
        sclk = ~pol;
        tick(3);
        sel_n[sel] = 1'b0;
        tick(4);
        for (int k = 0; k < nbytes; k++) shift_bits(txbuf[k], 8, pol);
        if (extra_bits > 0) shift_bits(8'hFF, extra_bits, pol);
        tick(4);
        sel_n[sel] = 1'b1;
        tick(8);
    endtask

    task automatic chk_lane(input int word, input int lane, input logic [7:0] wire_byte, input string req);
        rd_idx = word[4:0];
        #1;
        check(rd_data[lane*8 +: 8] === rev8(wire_byte), req, {56'b0, rd_data[lane*8 +: 8]}, {56'b0, rev8(wire_byte)});
    endtask

    task automatic t_reset;
        check(sel_n_o === 4'hF, "R12 selects pass after reset", {60'b0, sel_n_o}, 64'hF);
        txbuf[0] = 8'h5A;
        xfer(0, 1, 0, 1'b0); // control is zero: nothing captured (R12)
    endtask

    task automatic t_full_word;
        write_ctl(1'b1, 1'b1, 4'h0, 1'b0);
        for (int k = 0; k < 8; k++) txbuf[k] = 8'h11 * k[7:0] + 8'h03;
        txbuf[0] = 8'hC1;
        xfer(0, 8, 0, 1'b1);
        chk_lane(0, 0, 8'hC1, "R12 R4 first byte at word0 lane0");
        for (int k = 1; k < 8; k++) chk_lane(0, k, txbuf[k], "R5 R9 lane order");
    endtask

    task automatic t_round;
        txbuf[0] = 8'h81; txbuf[1] = 8'h42; txbuf[2] = 8'h24;
        xfer(1, 3, 0, 1'b1);
        chk_lane(1, 2, 8'h24, "R5 third byte in lane2");
        txbuf[0] = 8'hE7; txbuf[1] = 8'h18;
        xfer(1, 2, 0, 1'b1);
        chk_lane(2, 0, 8'hE7, "R6 next transaction at word2 lane0");
        chk_lane(2, 1, 8'h18, "R6 second byte lane1");
        chk_lane(1, 0, 8'h81, "R6 word1 kept");
    endtask

    task automatic t_partial;
        txbuf[0] = 8'h96;
        xfer(2, 1, 5, 1'b1);
        chk_lane(3, 0, 8'h96, "R7 complete byte kept");
        txbuf[0] = 8'h3B;
        xfer(2, 1, 0, 1'b1);
        chk_lane(4, 0, 8'h3B, "R7 partial byte dropped, next word");
    endtask

    task automatic t_gate;
        for (int i = 0; i < 16; i++) begin
            sclk = ~sclk;
            tick(2);
        end
        write_ctl(1'b1, 1'b0, 4'h0, 1'b0);
        txbuf[0] = 8'h77; txbuf[1] = 8'h66;
        xfer(0, 2, 0, 1'b1);
        write_ctl(1'b1, 1'b1, 4'h0, 1'b0);
        txbuf[0] = 8'hD4;
        xfer(0, 1, 0, 1'b1);
        chk_lane(5, 0, 8'hD4, "R3 no capture when disabled or deselected");
    endtask

    task automatic t_pol0;
        write_ctl(1'b0, 1'b1, 4'h0, 1'b0);
        for (int k = 0; k < 8; k++) txbuf[k] = 8'h29 + 8'h31 * k[7:0];
        xfer(3, 8, 0, 1'b0);
        for (int k = 0; k < 8; k++) chk_lane(6, k, txbuf[k], "R2 falling edge capture");
    endtask

    task automatic t_hold;
        write_ctl(1'b0, 1'b1, 4'b0010, 1'b0);
        tick(1);
        check(sel_n_o === 4'b1101, "R10 R1 hold forces select1 low", {60'b0, sel_n_o}, 64'hD);
        sel_n[2] = 1'b0;
        tick(1);
        check(sel_n_o === 4'b1001, "R10 other selects pass", {60'b0, sel_n_o}, 64'h9);
        sel_n[2] = 1'b1;
        write_ctl(1'b0, 1'b1, 4'b0000, 1'b0);
        tick(1);
        check(sel_n_o === 4'hF, "R10 hold cleared releases", {60'b0, sel_n_o}, 64'hF);
    endtask

    task automatic t_srst;
        write_ctl(1'b1, 1'b1, 4'h0, 1'b1);
        txbuf[0] = 8'h44;
        xfer(0, 1, 0, 1'b1);
        write_ctl(1'b1, 1'b1, 4'h0, 1'b0);
        txbuf[0] = 8'hB2;
        xfer(0, 1, 0, 1'b1);
        chk_lane(0, 0, 8'hB2, "R11 soft reset restarts at word0");
    endtask

    task automatic t_wrap;
        write_ctl(1'b1, 1'b1, 4'h0, 1'b1);
        write_ctl(1'b1, 1'b1, 4'h0, 1'b0);
        for (int k = 0; k < 256; k++) txbuf[k] = k[7:0] * 8'd7 + 8'd3;
        xfer(1, 256, 0, 1'b1);
        chk_lane(31, 7, txbuf[255], "R8 last byte in word31 lane7");
        chk_lane(17, 2, txbuf[138], "R8 middle of ring");
        txbuf[0] = 8'h0F;
        xfer(1, 1, 0, 1'b1);
        chk_lane(0, 0, 8'h0F, "R8 wrap to word0 lane0");
        chk_lane(0, 1, 8'd10, "R8 lane1 of word0 untouched");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_full_word();
        t_round();
        t_partial();
        t_gate();
        t_pol0();
        t_hold();
        t_srst();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule